// File: doc/BRIEF.md
# USB Suspend and Wakeup Controller

This block supervises the low-speed bus for power management. It watches the decoded line state from the receiver. When the bus stays idle long enough it reports a suspend event. Later bus activity reports a resume event. A falling edge on any key sense line or on any of four port lines reports a remote-wakeup event. All three events are sticky flags that firmware reads and clears by writing ones.

Firmware parks the device by setting a power-down bit. While that bit is set and clock stopping is enabled, the block asks for the oscillator to stop. The block clears power-down by itself when any of these happens: the bus line changes, a sense input is low, or port line 0 is low. Firmware can also drive a K state onto the bus to wake the host. A wake-disable bit vetoes both this drive and key-driven wakeup.

The key and port inputs are asynchronous. They pass through two-flop synchronizers before any logic uses them. The register port has two byte-wide addresses: control and events.

Top module: `usb_susp_wake_ctl`

## Requirements
- R1: After reset, both registers read 0, `clk_stop_o` is 0 and `bus_drive_k_o` is 0.
- R2: Line state uses these codes: SE0 = 2'b00, J = 2'b01 (idle), K = 2'b10. The suspend flag (event bit 0) sets on the clock edge at which the line has been J for IDLE_CYCLES consecutive edges, and not earlier. Any other code restarts the count.
- R3: Once suspend has been detected, and until the next non-idle line state, any change of `line_state_i` sets the resume flag (event bit 1) on the following edge. A line change at any other time does not set it.
- R4: A high-to-low transition on any `sense_i` bit or any `port_i` bit sets the remote-wakeup flag (event bit 2) when wake-disable is 0.
- R5: Event flags are cleared only by writing 1 to their bit at address 1. Writing 0 leaves them unchanged. A hardware set in the same cycle as a clear wins.
- R6: Any change of `line_state_i` clears the power-down bit (control bit 0) on the next edge.
- R7: While wake-disable is 0, power-down is cleared by any low `sense_i` bit or by a low `port_i[0]`. A low `port_i[3:1]` does not clear it.
- R8: `clk_stop_o` is 1 exactly when power-down and clock-stop enable (control bit 3) are both 1.
- R9: `bus_drive_k_o` is 1 while the wake-drive bit (control bit 2) is 1 and wake-disable (control bit 1) is 0.
- R10: With wake-disable set to 1, a key or port falling edge sets no flag and does not clear power-down.
- R11: A key or port input change takes effect at the third rising clock edge after it is applied, and not at the second.
- R12: Address 0 reads back control bits {clk_stop_en, wake_drive, wake_dis, pdown} in bits 3..0. Address 1 reads back {remote_wake, resume, suspend} in bits 2..0. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = events |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| line_state_i | input | 2 | Decoded bus state (SE0/J/K) |
| sense_i | input | N_SENSE | Key sense lines, asynchronous |
| port_i | input | N_PORT | Port wake lines, asynchronous |
| clk_stop_o | output | 1 | Oscillator stop request |
| bus_drive_k_o | output | 1 | Drive K state on the bus |

## Verification
The idle timer is run with an unbroken J period, and with a J period broken by one K cycle just short of expiry. The first shows the exact expiry edge and the second shows the restart. Resume is tried both with and without a prior suspend, which tells a real resume apart from an ordinary line change. Random rounds then pull down one sense or port line at a time under a random wake-disable setting. These rounds tell apart the sources that only flag an event from those that also end power-down. Directed pulses sampled at the second and third edge pin the synchronizer latency.

// File: rtl/usw_pkg.sv
package usw_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  localparam int unsigned EV_SUSP  = 0;
  localparam int unsigned EV_RES   = 1;
  localparam int unsigned EV_RWAKE = 2;
  localparam int unsigned N_EV     = 3;

  localparam int unsigned CT_PDOWN = 0;
  localparam int unsigned CT_WDIS  = 1;
  localparam int unsigned CT_WAKE  = 2;
  localparam int unsigned CT_CSEN  = 3;
endpackage

// File: rtl/usw_sync.sv
module usw_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/usw_idle_timer.sv
module usw_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 18000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so one idle stretch gives one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!idle_i)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = idle_i && (cnt_q == LIMIT - 1'b1);

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> cnt_q == '0);
  a_r2_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

// File: rtl/usw_flags.sv
module usw_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign q_o[g] = q;

    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !set_i[g] |=> !q_o[g]);
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o[g] && !clr_i[g] |=> q_o[g]);
  end
endmodule

// File: rtl/usb_susp_wake_ctl.sv
module usb_susp_wake_ctl
  import usw_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 18000,
  parameter int unsigned N_SENSE     = 8,
  parameter int unsigned N_PORT      = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [1:0]         line_state_i,
  input  logic [N_SENSE-1:0] sense_i,
  input  logic [N_PORT-1:0]  port_i,
  output logic               clk_stop_o,
  output logic               bus_drive_k_o
);
  localparam int unsigned NW = N_SENSE + N_PORT;

  logic [NW-1:0] wk_raw, wk_sync, wk_prev_q;
  logic [1:0]    line_prev_q;
  logic          bus_toggle, line_idle, idle_expire;
  logic          bus_susp_q;
  logic          key_fall, key_lvl;
  logic          pdown_q, wdis_q, wake_q, csen_q;
  logic          ctrl_we, ev_we;
  logic [N_EV-1:0] ev_set, ev_clr, ev_q;

  assign wk_raw = {port_i, sense_i};

  usw_sync #(.W(NW), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wk_raw),
    .q_o   (wk_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wk_prev_q   <= {NW{1'b1}};
      line_prev_q <= LS_J;
    end else begin
      wk_prev_q   <= wk_sync;
      line_prev_q <= line_state_i;
    end
  end

  assign bus_toggle = line_state_i != line_prev_q;
  assign line_idle  = line_state_i == LS_J;
  assign key_fall   = |(wk_prev_q & ~wk_sync);
  // sense lines and port line 0 end power-down by level
  assign key_lvl    = !wdis_q &&
                      ((|(~wk_sync[N_SENSE-1:0])) || !wk_sync[N_SENSE]);

  usw_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (line_idle),
    .expire_o(idle_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bus_susp_q <= 1'b0;
    else if (!line_idle)  bus_susp_q <= 1'b0;
    else if (idle_expire) bus_susp_q <= 1'b1;
  end

  assign ctrl_we = reg_we_i && !reg_addr_i;
  assign ev_we   = reg_we_i &&  reg_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdown_q <= 1'b0;
      wdis_q  <= 1'b0;
      wake_q  <= 1'b0;
      csen_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        wdis_q <= reg_wdata_i[CT_WDIS];
        wake_q <= reg_wdata_i[CT_WAKE];
        csen_q <= reg_wdata_i[CT_CSEN];
      end
      if (bus_toggle || key_lvl) pdown_q <= 1'b0;
      else if (ctrl_we)          pdown_q <= reg_wdata_i[CT_PDOWN];
    end
  end

  always_comb begin
    ev_set           = '0;
    ev_set[EV_SUSP]  = idle_expire;
    ev_set[EV_RES]   = bus_toggle && bus_susp_q;
    ev_set[EV_RWAKE] = key_fall && !wdis_q;
  end

  assign ev_clr = ev_we ? reg_wdata_i[N_EV-1:0] : '0;

  usw_flags #(.N(N_EV)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev_set),
    .clr_i (ev_clr),
    .q_o   (ev_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i) reg_rdata_o[N_EV-1:0] = ev_q;
    else            reg_rdata_o[3:0] = {csen_q, wake_q, wdis_q, pdown_q};
  end

  assign clk_stop_o    = pdown_q && csen_q;
  assign bus_drive_k_o = wake_q && !wdis_q;

  a_r6_pdown_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pdown_q) |-> $past(bus_toggle || key_lvl ||
                             (ctrl_we && !reg_wdata_i[CT_PDOWN])));
  a_r10_no_wake_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_q[EV_RWAKE]) |-> $past(!wdis_q));
  a_r3_resume_needs_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_q[EV_RES]) |-> $past(bus_susp_q));
  a_r6_toggle_ends_pdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_toggle |=> !pdown_q);
  a_r9_drive_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we && reg_wdata_i[CT_WDIS] |=> !bus_drive_k_o);
endmodule

// File: tb/sim_usb_susp_wake_ctl.sv
module sim_usb_susp_wake_ctl;
  localparam int unsigned IDLE = 18000;
  localparam int unsigned NS = 8;
  localparam int unsigned NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic          addr = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [1:0]    line = 2'b10;
  logic [NS-1:0] sense = '1;
  logic [NP-1:0] port = '1;
  logic          clk_stop, drive_k;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_susp_wake_ctl #(.IDLE_CYCLES(IDLE), .N_SENSE(NS), .N_PORT(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .line_state_i(line),
    .sense_i(sense), .port_i(port), .clk_stop_o(clk_stop),
    .bus_drive_k_o(drive_k)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic bit exp_pd_cleared(input int src, input bit dis);
    return !dis && (src < NS || src == NS);
  endfunction

  function automatic logic [7:0] ctrl_word(input bit csen, input bit wake,
                                           input bit dis, input bit pd);
    return {4'b0, csen, wake, dis, pd};
  endfunction

  initial begin
    logic [7:0] d;
    bit dis;
    int src;
    void'($urandom(32'h5eed_1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 / R12 reset state
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 events", d, 0);
    chk("R1 clk_stop", clk_stop, 0);
    chk("R1 drive_k", drive_k, 0);

    // R12 readback, R8, R9
    wr(0, ctrl_word(1, 1, 0, 1));
    rd(0, d); chk("R12 ctrl readback", d, 8'h0d);
    chk("R8 clk_stop on", clk_stop, 1);
    chk("R9 drive_k on", drive_k, 1);
    wr(0, ctrl_word(0, 1, 1, 1));
    chk("R8 clk_stop off when disabled", clk_stop, 0);
    chk("R9 drive_k blocked by disable", drive_k, 0);
    wr(0, 8'h00);
    chk("R9 drive_k released", drive_k, 0);

    // R11 latency of synchronizers
    sense[3] = 1'b0;
    tick(2);
    rd(1, d); chk("R11 not before third edge", d[2], 0);
    tick(1);
    rd(1, d); chk("R11 at third edge", d[2], 1);
    sense[3] = 1'b1; tick(3);
    // R5 write 0 no effect, write 1 clears
    wr(1, 8'h00);
    rd(1, d); chk("R5 write 0 keeps flag", d[2], 1);
    wr(1, 8'h04);
    rd(1, d); chk("R5 write 1 clears flag", d[2], 0);

    // R2 broken idle period then full one
    line = 2'b01;
    tick(IDLE - 5);
    line = 2'b10; tick(1);
    line = 2'b01;
    tick(IDLE - 1);
    rd(1, d); chk("R2 restart after K, one edge short", d[0], 0);
    rd(1, d); chk("R3 no resume without suspend", d[1], 0);
    tick(1);
    rd(1, d); chk("R2 suspend at limit", d[0], 1);

    // R3 / R6 resume clears power-down
    wr(0, ctrl_word(1, 0, 0, 1));
    chk("R8 clk_stop during suspend", clk_stop, 1);
    line = 2'b10; tick(1);
    rd(1, d); chk("R3 resume flag", d[1], 1);
    rd(0, d); chk("R6 pdown cleared by toggle", d[0], 0);
    chk("R8 clk_stop follows pdown", clk_stop, 0);
    wr(1, 8'h07);
    rd(1, d); chk("R5 all flags cleared", d, 0);

    // random rounds: R4 R7 R10
    for (int it = 0; it < 40; it++) begin
      dis = 1'($urandom % 2);
      src = int'($urandom % (NS + NP));
      wr(0, ctrl_word(1, 0, dis, 1));
      wr(1, 8'h07);
      if (src < NS) sense[src] = 1'b0; else port[src - NS] = 1'b0;
      tick(3);
      rd(1, d);
      chk(dis ? "R10 flag blocked" : "R4 remote wake flag", d[2], !dis);
      rd(0, d);
      chk(dis ? "R10 pdown kept" : "R7 pdown by source", d[0],
          !exp_pd_cleared(src, dis));
      chk("R8 clk_stop tracks pdown", clk_stop, !exp_pd_cleared(src, dis));
      sense = '1; port = '1;
      tick(3);
    end
    wr(0, 8'h00);
    wr(1, 8'h07);
    rd(1, d); chk("R5 final clear", d, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got %0d exp done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule